// File: doc/BRIEF.md
# Parallel ADC Host Sequencer

This block sits on the host side of a 12-bit parallel sampling converter and runs every pin the converter needs: the active-low conversion strobe, chip select, read strobe and shutdown, plus the power-level select. It also watches the converter's active-low busy output. A one-cycle request asks for a single conversion. Separate one-cycle requests enter a power-down level and leave it. Each returned word is held in an output register and announced by a one-cycle valid pulse.

There are two ways to collect a sample. In latch mode, chip select and read stay low, the converter's outputs are always driven, and the word is taken when busy returns high. In strobe mode, chip select stays low and read idles high. After busy returns high the block pulses read low and takes the word during the last low cycle. There are two power-down levels, a light one and a deep one. Each has its own wake-up delay in clock cycles. No conversion strobe is issued until that delay has run out. A conversion requested while the converter is down or waking is held and issued once the wait is over.

A busy watchdog raises a sticky error if busy fails to come back high within a set number of cycles.

Top module: `adc_host_seq`

## Requirements
- R1: After reset the block drives conversion strobe high, chip select low, read high, shutdown high and level select high (light level), with sample_valid and busy_err low.
- R2: A conversion request accepted in idle drives adc_convst_n low for exactly CONV_LOW_CYC cycles, with adc_cs_n low throughout.
- R3: The conversion strobe never falls while the synchronized busy input is low. A request made then is held and issued after busy returns high.
- R4: With read_mode = 0 (latch mode), adc_rd_n stays low. The word on adc_data is captured when busy returns high, and sample_valid pulses for one cycle with that word on sample_data.
- R5: With read_mode = 1 (strobe mode), adc_rd_n is high outside reads. After busy returns high it goes low for exactly RD_LOW_CYC cycles, and the word present in the last low cycle is captured and flagged with a one-cycle sample_valid.
- R6: A power-down request in idle sets adc_nap_sel to the inverse of pd_deep (1 = light, 0 = deep) at least one cycle before adc_shdn_n falls. While adc_shdn_n is low, adc_convst_n and adc_cs_n are both high.
- R7: After a wake request, adc_shdn_n rises. The next conversion strobe falls no earlier than NAP_WAKE_CYC cycles later for the light level, or SLEEP_WAKE_CYC cycles later for the deep level.
- R8: A conversion request made during shutdown or during the wake wait produces exactly one conversion once the wait ends.
- R9: If busy is not back high within BUSY_TO_CYC cycles of the strobe falling, busy_err is set, no sample_valid is produced and the block returns to idle. busy_err clears when the next conversion starts.
- R10: A conversion request that arrives while a conversion or read is in progress is dropped and causes no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | One-cycle request for a conversion |
| pd_req | input | 1 | One-cycle request to enter power-down |
| pd_deep | input | 1 | Level for pd_req: 0 light, 1 deep |
| wake_req | input | 1 | One-cycle request to leave power-down |
| read_mode | input | 1 | 0 latch on busy rise, 1 read strobe; sampled in idle |
| adc_busy_n | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_data | input | DATA_W | Converter data bus |
| adc_convst_n | output | 1 | Conversion strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_shdn_n | output | 1 | Shutdown, active low |
| adc_nap_sel | output | 1 | Power level select: 1 light, 0 deep |
| sample_data | output | DATA_W | Last captured word |
| sample_valid | output | 1 | One-cycle pulse when sample_data is updated |
| busy_err | output | 1 | Sticky busy timeout flag |
| in_shutdown | output | 1 | High while powered down or waking |

## Verification
The assertions take for granted that the converter only pulls busy low in answer to a strobe, and that busy then returns high within the timeout unless the timeout itself is under test. They also assume requests are single-cycle pulses. The bench's converter model keeps to this. It drops busy two cycles after seeing the strobe fall, holds it low for a fixed time and then raises it with a new word. Busy is held low on its own only in the guard and timeout scenarios, and only while idle or after a strobe. Power-down and wake requests are issued only from idle and from shutdown, matching what the block accepts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_READ   = 3'd3,
        ST_PD_SET = 3'd4,
        ST_PD     = 3'd5,
        ST_WAKE   = 3'd6
    } seq_state_e;

    typedef enum logic {
        RM_LATCH  = 1'b0,
        RM_STROBE = 1'b1
    } read_mode_e;

    typedef enum logic {
        PD_LIGHT = 1'b0,
        PD_DEEP  = 1'b1
    } pd_level_e;

    typedef struct packed {
        logic convst_n;
        logic cs_n;
        logic rd_n;
        logic shdn_n;
    } pin_set_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_set_t pin_drive(input seq_state_e st, input read_mode_e md);
        pin_set_t p;
        p.convst_n = (st != ST_START);
        p.cs_n     = (st == ST_PD) || (st == ST_WAKE);
        p.shdn_n   = (st != ST_PD);
        if (md == RM_LATCH) p.rd_n = 1'b0;
        else                p.rd_n = (st != ST_READ);
        return p;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R7: a running count only moves down by one per cycle
    p_timer_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_seq_busy_mon.sv
module adc_seq_busy_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int TO_CYC      = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_n_async,
    input  logic arm,
    input  logic active,
    output logic busy_n_sync,
    output logic rise,
    output logic timeout
);
    localparam int TW = adc_seq_pkg::cnt_w(TO_CYC);

    logic          seen_low_q;
    logic [TW-1:0] to_cnt_q;

    generate
        if (SYNC_STAGES <= 1) begin : g_one
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= busy_n_async;
            end
            assign busy_n_sync = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] sh_q;
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[SYNC_STAGES-2:0], busy_n_async};
            end
            assign busy_n_sync = sh_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_low_q <= 1'b0;
            to_cnt_q   <= '0;
        end else if (arm) begin
            seen_low_q <= 1'b0;
            to_cnt_q   <= '0;
        end else if (active) begin
            if (!busy_n_sync) seen_low_q <= 1'b1;
            if (to_cnt_q != TW'(TO_CYC)) to_cnt_q <= to_cnt_q + 1'b1;
        end
    end

    assign rise    = active && seen_low_q && busy_n_sync;
    assign timeout = active && (to_cnt_q == TW'(TO_CYC));

    // R3: the sequencer only arms a conversion while busy reads high
    p_arm_busy_high_r3: assert property (@(posedge clk) disable iff (rst)
        arm |-> busy_n_sync);
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= take;
            if (take) dout <= din;
        end
    end

    // R4: valid is a single-cycle pulse
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int CONV_LOW_CYC   = 3,
    parameter int RD_LOW_CYC     = 2,
    parameter int NAP_WAKE_CYC   = 25,
    parameter int SLEEP_WAKE_CYC = 1250000,
    parameter int BUSY_TO_CYC    = 1000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_req,
    input  logic              pd_req,
    input  logic              pd_deep,
    input  logic              wake_req,
    input  logic              read_mode,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_convst_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_shdn_n,
    output logic              adc_nap_sel,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid,
    output logic              busy_err,
    output logic              in_shutdown
);
    localparam int PW = cnt_w(max2(CONV_LOW_CYC, RD_LOW_CYC));
    localparam int WW = cnt_w(max2(NAP_WAKE_CYC, SLEEP_WAKE_CYC));

    seq_state_e state_q, state_d;
    read_mode_e mode_q;
    pd_level_e  lvl_q;
    logic       nap_q, pend_q, err_q;

    logic          go, take, err_set, p_load, w_load;
    logic [PW-1:0] p_val;
    logic [WW-1:0] w_val;
    logic          p_exp, w_exp;
    logic          busy_sync, busy_rise, busy_to, mon_active;
    logic          pend_ok;
    pin_set_t      pins;

    adc_seq_timer #(.W(PW)) u_pulse (
        .clk(clk), .rst(rst), .load(p_load), .load_val(p_val), .expired(p_exp));

    adc_seq_timer #(.W(WW)) u_wake (
        .clk(clk), .rst(rst), .load(w_load), .load_val(w_val), .expired(w_exp));

    assign mon_active = (state_q == ST_START) || (state_q == ST_WAIT);

    adc_seq_busy_mon #(.SYNC_STAGES(SYNC_STAGES), .TO_CYC(BUSY_TO_CYC)) u_busy (
        .clk(clk), .rst(rst), .busy_n_async(adc_busy_n), .arm(go),
        .active(mon_active), .busy_n_sync(busy_sync), .rise(busy_rise),
        .timeout(busy_to));

    adc_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .take(take), .din(adc_data),
        .dout(sample_data), .valid(sample_valid));

    assign w_val = (lvl_q == PD_DEEP) ? WW'(SLEEP_WAKE_CYC) : WW'(NAP_WAKE_CYC);

    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        take    = 1'b0;
        err_set = 1'b0;
        p_load  = 1'b0;
        p_val   = '0;
        w_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pd_req) begin
                    state_d = ST_PD_SET;
                end else if ((pend_q || conv_req) && busy_sync) begin
                    state_d = ST_START;
                    go      = 1'b1;
                    p_load  = 1'b1;
                    p_val   = PW'(CONV_LOW_CYC - 1);
                end
            end
            ST_START: if (p_exp) state_d = ST_WAIT;
            ST_WAIT: begin
                if (busy_rise) begin
                    if (mode_q == RM_LATCH) begin
                        take    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_READ;
                        p_load  = 1'b1;
                        p_val   = PW'(RD_LOW_CYC - 1);
                    end
                end else if (busy_to) begin
                    err_set = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_READ: begin
                if (p_exp) begin
                    take    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_PD_SET: state_d = ST_PD;
            ST_PD: begin
                if (wake_req) begin
                    state_d = ST_WAKE;
                    w_load  = 1'b1;
                end
            end
            ST_WAKE: if (w_exp) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign pend_ok = (state_q == ST_IDLE) || (state_q == ST_PD_SET) ||
                     (state_q == ST_PD)   || (state_q == ST_WAKE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= RM_STROBE;
            lvl_q   <= PD_LIGHT;
            nap_q   <= 1'b1;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) mode_q <= read_mode_e'(read_mode);
            if (state_q == ST_IDLE && pd_req) begin
                lvl_q <= pd_level_e'(pd_deep);
                nap_q <= ~pd_deep;
            end
            if (go)                       pend_q <= 1'b0;
            else if (conv_req && pend_ok) pend_q <= 1'b1;
            if (go)           err_q <= 1'b0;
            else if (err_set) err_q <= 1'b1;
        end
    end

    assign pins         = pin_drive(state_q, mode_q);
    assign adc_convst_n = pins.convst_n;
    assign adc_cs_n     = pins.cs_n;
    assign adc_rd_n     = pins.rd_n;
    assign adc_shdn_n   = pins.shdn_n;
    assign adc_nap_sel  = nap_q;
    assign busy_err     = err_q;
    assign in_shutdown  = (state_q == ST_PD) || (state_q == ST_WAKE);

    // R2: strobe low only with chip selected
    p_cs_with_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !adc_convst_n |-> !adc_cs_n);

    // R6: level select is steady across the shutdown falling edge
    p_level_setup_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_shdn_n) |-> $stable(adc_nap_sel));

    // R6: converter left alone while shut down
    p_quiet_shdn_r6: assert property (@(posedge clk) disable iff (rst)
        !adc_shdn_n |-> (adc_convst_n && adc_cs_n));

    // R5: in strobe mode a sample follows a read-low cycle
    p_strobe_read_r5: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && mode_q == RM_STROBE) |-> $past(!adc_rd_n));

    // R9: a timeout never delivers a sample
    p_err_no_sample_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_err) |-> !sample_valid);

    // R7: no strobe during the wake wait
    p_wake_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        in_shutdown |-> adc_convst_n);
endmodule

// File: tb/adc_host_seq_tb_top.sv
`timescale 1ns/1ps
module adc_host_seq_tb_top;
    localparam int DW    = 12;
    localparam int CONVL = 3;
    localparam int RDL   = 2;
    localparam int NAPW  = 25;
    localparam int SLPW  = 300;
    localparam int BTO   = 60;
    localparam int MCONV = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_req = 0, pd_req = 0, pd_deep = 0, wake_req = 0, read_mode = 1;
    logic adc_busy_n;
    logic [DW-1:0] adc_data;
    logic adc_convst_n, adc_cs_n, adc_rd_n, adc_shdn_n, adc_nap_sel;
    logic [DW-1:0] sample_data;
    logic sample_valid, busy_err, in_shutdown;

    always #4 clk = ~clk;

    adc_host_seq #(.DATA_W(DW), .CONV_LOW_CYC(CONVL), .RD_LOW_CYC(RDL),
                   .NAP_WAKE_CYC(NAPW), .SLEEP_WAKE_CYC(SLPW),
                   .BUSY_TO_CYC(BTO), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .conv_req(conv_req), .pd_req(pd_req),
        .pd_deep(pd_deep), .wake_req(wake_req), .read_mode(read_mode),
        .adc_busy_n(adc_busy_n), .adc_data(adc_data),
        .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_shdn_n(adc_shdn_n), .adc_nap_sel(adc_nap_sel),
        .sample_data(sample_data), .sample_valid(sample_valid),
        .busy_err(busy_err), .in_shutdown(in_shutdown));

    // converter model
    logic          m_busy_n = 1'b1;
    logic [DW-1:0] m_word = 12'h0A5;
    logic          m_prev_cn = 1'b1;
    int            m_phase = 0, m_cnt = 0;
    logic          hang = 1'b0, force_low = 1'b0;

    always @(posedge clk) begin
        m_prev_cn <= adc_convst_n;
        case (m_phase)
            0: if (m_prev_cn && !adc_convst_n) begin m_phase <= 1; m_cnt <= 2; end
            1: if (m_cnt <= 1) begin m_busy_n <= 1'b0; m_phase <= 2; m_cnt <= MCONV; end
               else m_cnt <= m_cnt - 1;
            default: begin
                if (m_cnt > 1) m_cnt <= m_cnt - 1;
                else if (!hang) begin
                    m_word   <= m_word + 12'h135;
                    m_busy_n <= 1'b1;
                    m_phase  <= 0;
                end
            end
        endcase
    end
    assign adc_busy_n = m_busy_n & ~force_low;
    assign adc_data   = (read_mode == 1'b0 || !adc_rd_n) ? m_word : '0;

    // port monitors, sampled at negedge
    int cyc = 0, conv_falls = 0, last_conv_fall = 0, last_shdn_rise = 0;
    int cl_run = 0, cl_width = 0, rd_run = 0, rd_width = 0, valid_count = 0;
    logic p_cn = 1'b1, p_rd = 1'b1, p_sh = 1'b1, p_nap = 1'b1;
    logic nap_before = 1'b1, nap_at = 1'b1;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (p_cn && !adc_convst_n) begin conv_falls <= conv_falls + 1; last_conv_fall <= cyc; end
            if (!adc_convst_n) cl_run <= cl_run + 1;
            else if (!p_cn) begin cl_width <= cl_run; cl_run <= 0; end
            if (!adc_rd_n) rd_run <= rd_run + 1;
            else if (!p_rd) begin rd_width <= rd_run; rd_run <= 0; end
            if (!p_sh && adc_shdn_n) last_shdn_rise <= cyc;
            if (p_sh && !adc_shdn_n) begin nap_before <= p_nap; nap_at <= adc_nap_sel; end
            if (sample_valid) valid_count <= valid_count + 1;
        end
        p_cn  <= adc_convst_n;
        p_rd  <= adc_rd_n;
        p_sh  <= adc_shdn_n;
        p_nap <= adc_nap_sel;
    end

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_conv();
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
    endtask

    task automatic wait_valid(input int vc0, input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (valid_count != vc0) begin got = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        chk(adc_convst_n == 1, "R1", "convst_n", adc_convst_n, 1);
        chk(adc_cs_n == 0, "R1", "cs_n", adc_cs_n, 0);
        chk(adc_rd_n == 1, "R1", "rd_n", adc_rd_n, 1);
        chk(adc_shdn_n == 1 && adc_nap_sel == 1, "R1", "shdn_n/nap_sel",
            {adc_shdn_n, adc_nap_sel}, 3);
        chk(sample_valid == 0 && busy_err == 0, "R1", "valid/err",
            {sample_valid, busy_err}, 0);
    endtask

    task automatic t_latch();
        bit got; int vc;
        read_mode = 1'b0; idle(2);
        chk(adc_rd_n == 0, "R4", "rd_n held low in latch mode", adc_rd_n, 0);
        vc = valid_count;
        pulse_conv();
        wait_valid(vc, 200, got);
        chk(got, "R4", "sample_valid seen", got, 1);
        chk(sample_data == m_word, "R4", "latched word", sample_data, m_word);
        chk(cl_width == CONVL, "R2", "strobe low width", cl_width, CONVL);
        @(negedge clk);
        chk(!sample_valid, "R4", "valid one cycle", sample_valid, 0);
    endtask

    task automatic t_strobe();
        bit got; int vc;
        read_mode = 1'b1; idle(2);
        chk(adc_rd_n == 1, "R5", "rd_n idle high", adc_rd_n, 1);
        vc = valid_count;
        pulse_conv();
        wait_valid(vc, 200, got);
        chk(got, "R5", "sample_valid seen", got, 1);
        chk(sample_data == m_word, "R5", "read word", sample_data, m_word);
        chk(rd_width == RDL, "R5", "read low width", rd_width, RDL);
        chk(adc_rd_n == 1, "R5", "rd_n back high", adc_rd_n, 1);
    endtask

    task automatic t_busy_guard();
        bit got; int vc, cf;
        force_low = 1'b1; idle(4);
        cf = conv_falls; vc = valid_count;
        pulse_conv(); idle(30);
        chk(conv_falls == cf, "R3", "no strobe while busy low", conv_falls - cf, 0);
        force_low = 1'b0;
        wait_valid(vc, 200, got);
        chk(got && conv_falls == cf + 1, "R3", "held request issued once",
            conv_falls - cf, 1);
    endtask

    task automatic t_drop_extra();
        bit got; int vc, cf;
        cf = conv_falls; vc = valid_count;
        pulse_conv(); idle(8);
        pulse_conv();
        wait_valid(vc, 200, got);
        idle(40);
        chk(conv_falls == cf + 1, "R10", "request during conversion dropped",
            conv_falls - cf, 1);
    endtask

    task automatic t_power(input bit deep, input int wait_cyc, input string rq);
        bit got; int vc, cf;
        @(negedge clk) begin pd_req = 1'b1; pd_deep = deep; end
        @(negedge clk) pd_req = 1'b0;
        idle(3);
        chk(adc_shdn_n == 0, "R6", "shdn_n low", adc_shdn_n, 0);
        chk(adc_nap_sel == !deep, "R6", "level select", adc_nap_sel, !deep);
        chk(nap_before == nap_at, "R6", "level set before shdn fall", nap_before, nap_at);
        chk(adc_cs_n == 1 && adc_convst_n == 1, "R6", "pins idle in shutdown",
            {adc_cs_n, adc_convst_n}, 3);
        cf = conv_falls; vc = valid_count;
        pulse_conv(); idle(10);
        chk(conv_falls == cf, "R8", "request held in shutdown", conv_falls - cf, 0);
        @(negedge clk) wake_req = 1'b1;
        @(negedge clk) wake_req = 1'b0;
        wait_valid(vc, wait_cyc + 200, got);
        chk(got, "R8", "pending conversion completed", got, 1);
        chk(last_conv_fall - last_shdn_rise >= wait_cyc, rq, "wake delay",
            last_conv_fall - last_shdn_rise, wait_cyc);
        idle(40);
        chk(conv_falls == cf + 1, "R8", "exactly one conversion", conv_falls - cf, 1);
    endtask

    task automatic t_timeout();
        bit got; int vc;
        hang = 1'b1;
        vc = valid_count;
        pulse_conv(); idle(BTO + 20);
        chk(busy_err == 1, "R9", "busy_err set", busy_err, 1);
        chk(valid_count == vc, "R9", "no sample on timeout", valid_count - vc, 0);
        hang = 1'b0; idle(10);
        pulse_conv();
        chk(busy_err == 0, "R9", "busy_err cleared on start", busy_err, 0);
        wait_valid(vc, 200, got);
        chk(got, "R9", "recovery conversion", got, 1);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch();
        t_strobe();
        t_busy_guard();
        t_drop_extra();
        t_power(1'b0, NAPW, "R7");
        t_power(1'b1, SLPW, "R7");
        t_timeout();
        idle(5);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule